// File: doc/BRIEF.md
# Supervisory Reset Controller

This block produces the system reset for a processor subsystem. Reset is driven while a low-supply flag is raised, and it is held for a fixed hold time after the flag clears, so the supply can settle before software runs. Reset is also driven after the block's own power-on clear, for the same hold time.

A watchdog runs beside the supply monitor. The host restarts it by pulling its chip-select line low for at least a minimum number of clock cycles. A shorter low glitch does not restart it. The host chooses a long, medium or short timeout with a 2-bit code, and one code value turns the watchdog off. If no valid restart arrives within the timeout, the block drives a reset pulse that lasts the hold time. A chip select that stays high or stays low therefore ends in a reset.

All durations are counted in ticks from a prescaler. The prescaler divide is a parameter, so a bench can shorten every time. A parameter also sets the reset polarity. The low-supply flag and chip select each pass through a two-flop synchronizer.

Top module: `sup_reset_ctrl`

## Requirements
- R1: `rst_o` is low while reset is asserted when `RST_ACTIVE_HIGH` is 0, and high while reset is asserted when it is 1. The two builds differ only in this polarity.
- R2: Once `low_supply_i` is high, reset is asserted no later than the third rising clock edge, and it stays asserted for as long as the flag stays high.
- R3: After `low_supply_i` falls, reset stays asserted for `HOLD_TICKS` ticks (one tick = `TICK_DIV` clocks), give or take one tick of prescaler phase, and then releases.
- R4: The timeout code `wd_sel_i` selects the timeout. 2'b00 gives `T_LONG` ticks, 2'b01 gives `T_MID` ticks and 2'b10 gives `T_SHORT` ticks. 2'b11 disables the watchdog, so it never expires.
- R5: When the watchdog expires, reset is asserted for `HOLD_TICKS` ticks and then released.
- R6: A low period on `cs_n_i` restarts the watchdog count only if it lasts at least `KICK_MIN_CYC` clocks. A low period one clock shorter has no effect.
- R7: If `cs_n_i` stays high, the watchdog expires. If `cs_n_i` stays low, it restarts once and then expires.
- R8: The watchdog count is held at zero while reset is asserted, so a full timeout is counted from the moment reset releases.
- R9: A change of `wd_sel_i` restarts the watchdog count.
- R10: Reset is asserted while `arst_ni` is low. After `arst_ni` releases, reset stays asserted for `HOLD_TICKS` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| arst_ni | input | 1 | Asynchronous power-on clear, active low |
| low_supply_i | input | 1 | Low-supply flag from the analog detector, asynchronous, active high |
| cs_n_i | input | 1 | Host chip select, asynchronous, active low; a long enough low period restarts the watchdog |
| wd_sel_i | input | 2 | Watchdog timeout code |
| rst_o | output | 1 | System reset; polarity set by `RST_ACTIVE_HIGH` |

## Verification
The bench builds two instances with the prescaler divide set to 4, a hold of 8 ticks and timeouts of 56, 24 and 8 ticks. One instance has an active-low output and the other an active-high output. These short values let the bench run every timeout code to expiry, several hold periods and the disabled code, all within a few thousand cycles. The minimum chip-select low width is set to 5 clocks, so the bench can test a 5-clock pulse against a 4-clock pulse to check the restart boundary.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_LOWV = 2'd1,
    ST_HOLD = 2'd2,
    ST_WDP  = 2'd3
  } sup_state_e;

  localparam logic [1:0] SEL_OFF = 2'b11;

  // timeout in ticks for a select code; 0 for the disabled code
  function automatic int unsigned wd_limit(input logic [1:0] code,
                                           input int unsigned t_long,
                                           input int unsigned t_mid,
                                           input int unsigned t_short);
    case (code)
      2'b00:   return t_long;
      2'b01:   return t_mid;
      2'b10:   return t_short;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // bits needed to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter logic INIT = 1'b0
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      s1_q <= INIT;
      s2_q <= INIT;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sup_prescaler.sv
module sup_prescaler #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic tick_o
);
  localparam int unsigned PW = sup_pkg::cnt_width(DIV - 1);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + PW'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/sup_kick_filter.sv
module sup_kick_filter #(
  parameter int unsigned MIN_LOW = 20
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic cs_n_s_i,
  output logic kick_o
);
  localparam int unsigned KW = sup_pkg::cnt_width(MIN_LOW);
  localparam logic [KW-1:0] SAT  = KW'(MIN_LOW);
  localparam logic [KW-1:0] FIRE = KW'(MIN_LOW - 1);

  logic [KW-1:0] low_q;

  // counts synchronized low cycles, saturating
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)        low_q <= '0;
    else if (cs_n_s_i)   low_q <= '0;
    else if (low_q != SAT) low_q <= low_q + KW'(1);
  end

  // one pulse on the MIN_LOW-th low cycle
  assign kick_o = !cs_n_s_i && (low_q == FIRE);
endmodule

// File: rtl/sup_reset_fsm.sv
module sup_reset_fsm
  import sup_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 200,
  parameter int unsigned T_LONG     = 1400,
  parameter int unsigned T_MID      = 600,
  parameter int unsigned T_SHORT    = 200,
  parameter int unsigned WD_W       = 11,
  parameter int unsigned HW         = 8
) (
  input  logic            clk_i,
  input  logic            arst_ni,
  input  logic            tick_i,
  input  logic            lv_s_i,
  input  logic            kick_i,
  input  logic [1:0]      sel_i,
  output logic            rst_active_o,
  output logic            wd_expire_o,
  output logic            sel_chg_o,
  output logic [1:0]      sel_q_o,
  output logic [WD_W-1:0] wd_cnt_o,
  output logic [HW-1:0]   hold_cnt_o
);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

  sup_state_e      st_q, st_d;
  logic [WD_W-1:0] wd_q, wd_d;
  logic [HW-1:0]   hd_q, hd_d;
  logic [1:0]      sel_q;
  logic            wd_en;
  logic [WD_W-1:0] wd_last;
  logic            expire;

  assign sel_chg_o = (sel_i != sel_q);
  assign wd_en     = (sel_q != SEL_OFF);
  assign wd_last   = WD_W'(wd_limit(sel_q, T_LONG, T_MID, T_SHORT) - 1);
  assign expire    = (st_q == ST_RUN) && !lv_s_i && wd_en && !sel_chg_o &&
                     !kick_i && tick_i && (wd_q == wd_last);

  always_comb begin
    st_d = st_q;
    wd_d = wd_q;
    hd_d = hd_q;
    if (lv_s_i) begin
      st_d = ST_LOWV;
      wd_d = '0;
      hd_d = '0;
    end else begin
      unique case (st_q)
        ST_LOWV: begin
          st_d = ST_HOLD;
          wd_d = '0;
          hd_d = '0;
        end
        ST_HOLD, ST_WDP: begin
          wd_d = '0;
          if (tick_i) begin
            if (hd_q == HOLD_LAST) begin
              st_d = ST_RUN;
              hd_d = '0;
            end else begin
              hd_d = hd_q + HW'(1);
            end
          end
        end
        default: begin
          if (sel_chg_o || kick_i) begin
            wd_d = '0;
          end else if (expire) begin
            st_d = ST_WDP;
            wd_d = '0;
            hd_d = '0;
          end else if (wd_en && tick_i) begin
            wd_d = wd_q + WD_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      st_q  <= ST_HOLD;
      wd_q  <= '0;
      hd_q  <= '0;
      sel_q <= 2'b00;
    end else begin
      st_q  <= st_d;
      wd_q  <= wd_d;
      hd_q  <= hd_d;
      sel_q <= sel_i;
    end
  end

  assign rst_active_o = (st_q != ST_RUN);
  assign wd_expire_o  = expire;
  assign sel_q_o      = sel_q;
  assign wd_cnt_o     = wd_q;
  assign hold_cnt_o   = hd_q;
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int unsigned TICK_DIV        = 50000,
  parameter int unsigned KICK_MIN_CYC    = 20,
  parameter int unsigned HOLD_TICKS      = 200,
  parameter int unsigned T_LONG          = 1400,
  parameter int unsigned T_MID           = 600,
  parameter int unsigned T_SHORT         = 200,
  parameter bit          RST_ACTIVE_HIGH = 1'b0
) (
  input  logic       clk_i,
  input  logic       arst_ni,
  input  logic       low_supply_i,
  input  logic       cs_n_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_o
);
  localparam int unsigned WD_W = sup_pkg::cnt_width(sup_pkg::max3(T_LONG, T_MID, T_SHORT));
  localparam int unsigned HW   = sup_pkg::cnt_width(HOLD_TICKS);

  logic            lv_s, cs_s, tick, kick;
  logic            rst_active, wd_expire, sel_chg;
  logic [1:0]      sel_q;
  logic [WD_W-1:0] wd_cnt;
  logic [HW-1:0]   hold_cnt;

  sup_sync #(.INIT(1'b0)) u_lv_sync (
    .clk_i(clk_i), .arst_ni(arst_ni), .d_i(low_supply_i), .q_o(lv_s)
  );

  sup_sync #(.INIT(1'b1)) u_cs_sync (
    .clk_i(clk_i), .arst_ni(arst_ni), .d_i(cs_n_i), .q_o(cs_s)
  );

  sup_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i(clk_i), .arst_ni(arst_ni), .tick_o(tick)
  );

  sup_kick_filter #(.MIN_LOW(KICK_MIN_CYC)) u_kick (
    .clk_i(clk_i), .arst_ni(arst_ni), .cs_n_s_i(cs_s), .kick_o(kick)
  );

  sup_reset_fsm #(
    .HOLD_TICKS(HOLD_TICKS), .T_LONG(T_LONG), .T_MID(T_MID), .T_SHORT(T_SHORT),
    .WD_W(WD_W), .HW(HW)
  ) u_fsm (
    .clk_i(clk_i), .arst_ni(arst_ni), .tick_i(tick), .lv_s_i(lv_s),
    .kick_i(kick), .sel_i(wd_sel_i), .rst_active_o(rst_active),
    .wd_expire_o(wd_expire), .sel_chg_o(sel_chg), .sel_q_o(sel_q),
    .wd_cnt_o(wd_cnt), .hold_cnt_o(hold_cnt)
  );

  generate
    if (RST_ACTIVE_HIGH) begin : g_pol_hi
      assign rst_o = rst_active;
    end else begin : g_pol_lo
      assign rst_o = ~rst_active;
    end
  endgenerate
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk #(
  parameter int unsigned HOLD_TICKS = 200,
  parameter int unsigned WD_W       = 11,
  parameter int unsigned HW         = 8
) (
  input logic            clk_i,
  input logic            arst_ni,
  input logic            lv_s,
  input logic            cs_s,
  input logic            kick,
  input logic            sel_chg,
  input logic [1:0]      sel_q,
  input logic            wd_expire,
  input logic            rst_active,
  input logic [WD_W-1:0] wd_cnt,
  input logic [HW-1:0]   hold_cnt
);
  // R2
  low_supply_assert_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    lv_s |=> rst_active);

  // R3
  hold_after_low_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $fell(lv_s) |=> rst_active && (hold_cnt == '0));

  // R4
  wd_off_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (sel_q == 2'b11) |-> !wd_expire);

  // R5
  wd_pulse_start_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    wd_expire |=> rst_active && (hold_cnt == '0));

  // R5
  hold_range_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    hold_cnt < HW'(HOLD_TICKS));

  // R6
  kick_low_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    kick |-> !cs_s);

  // R8
  count_restart_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rst_active |-> (wd_cnt == '0));

  // R9
  sel_restart_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
    sel_chg |=> (wd_cnt == '0));
endmodule

bind sup_reset_ctrl sup_reset_chk #(
  .HOLD_TICKS(HOLD_TICKS), .WD_W(WD_W), .HW(HW)
) u_chk (
  .clk_i(clk_i), .arst_ni(arst_ni), .lv_s(lv_s), .cs_s(cs_s), .kick(kick),
  .sel_chg(sel_chg), .sel_q(sel_q), .wd_expire(wd_expire),
  .rst_active(rst_active), .wd_cnt(wd_cnt), .hold_cnt(hold_cnt)
);

// File: tb/tb_sup_reset_ctrl.sv
module tb_sup_reset_ctrl;
  localparam int DIV  = 4;
  localparam int KMIN = 5;
  localparam int H    = 8;
  localparam int TL   = 56;
  localparam int TM   = 24;
  localparam int TS   = 8;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       lv = 1'b0;
  logic       cs = 1'b1;
  logic [1:0] sel = 2'b10;
  logic       rst_lo, rst_hi;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sup_reset_ctrl #(.TICK_DIV(DIV), .KICK_MIN_CYC(KMIN), .HOLD_TICKS(H),
    .T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .RST_ACTIVE_HIGH(1'b0)) dut (
    .clk_i(clk), .arst_ni(arst_n), .low_supply_i(lv), .cs_n_i(cs),
    .wd_sel_i(sel), .rst_o(rst_lo));

  sup_reset_ctrl #(.TICK_DIV(DIV), .KICK_MIN_CYC(KMIN), .HOLD_TICKS(H),
    .T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .RST_ACTIVE_HIGH(1'b1)) dut_hi (
    .clk_i(clk), .arst_ni(arst_n), .low_supply_i(lv), .cs_n_i(cs),
    .wd_sel_i(sel), .rst_o(rst_hi));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // mode: 0 running, 1 supply low, 2 holding, 3 watchdog pulse
  int   m_mode, m_phase, m_hold, m_wd, m_low;
  logic m_lv[$];
  logic m_cs[$];
  logic [1:0] m_sel;

  function automatic int timeout_of(input logic [1:0] c);
    if (c == 2'b00) return TL;
    if (c == 2'b01) return TM;
    if (c == 2'b10) return TS;
    return -1;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_mode = 2; m_phase = 0; m_hold = 0; m_wd = 0; m_low = 0; m_sel = 2'b00;
      m_lv = '{1'b0, 1'b0};
      m_cs = '{1'b1, 1'b1};
    end else begin
      bit tk, kk, ch, lvs, css;
      lvs = m_lv[0];
      css = m_cs[0];
      tk  = (m_phase == DIV - 1);
      kk  = !css && (m_low == KMIN - 1);
      ch  = (sel != m_sel);
      if (lvs) begin
        m_mode = 1; m_hold = 0; m_wd = 0;
      end else if (m_mode == 1) begin
        m_mode = 2;
      end else if (m_mode >= 2) begin
        if (tk) begin
          if (m_hold == H - 1) begin m_mode = 0; m_hold = 0; end
          else m_hold++;
        end
      end else begin
        if (ch || kk) m_wd = 0;
        else if (timeout_of(m_sel) > 0 && tk) begin
          if (m_wd == timeout_of(m_sel) - 1) begin m_mode = 3; m_wd = 0; m_hold = 0; end
          else m_wd++;
        end
      end
      m_low   = css ? 0 : ((m_low < KMIN) ? m_low + 1 : m_low);
      m_phase = tk ? 0 : m_phase + 1;
      m_sel   = sel;
      void'(m_lv.pop_front()); m_lv.push_back(lv);
      void'(m_cs.pop_front()); m_cs.push_back(cs);
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    logic exp_lo;
    string tag;
    cyc++;
    exp_lo = (m_mode == 0);
    case (m_mode)
      0: tag = "R4";
      1: tag = "R2";
      2: tag = "R3";
      default: tag = "R5";
    endcase
    if (!done) begin
      chk(rst_lo === exp_lo, tag, int'(rst_lo), int'(exp_lo));
      // R1: opposite polarity build
      chk(rst_hi === ~rst_lo, "R1", int'(rst_hi), int'(~rst_lo));
    end
    if (cyc > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_pulse(input int low);
    @(negedge clk); cs = 1'b0;
    repeat (low) @(negedge clk);
    cs = 1'b1;
  endtask

  task automatic wait_lvl(input logic lvl, input int maxc, output int n);
    n = 0;
    while (rst_lo !== lvl && n < maxc) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic in_win(input string req, input int n, input int lo, input int hi);
    chk(n >= lo && n <= hi, req, n, lo);
  endtask

  initial begin
    int n;
    bit seen;
    // R10 / R1: reset state
    step(3);
    chk(rst_lo === 1'b0, "R10", int'(rst_lo), 0);
    chk(rst_hi === 1'b1, "R1", int'(rst_hi), 1);
    @(negedge clk); arst_n = 1'b1;
    wait_lvl(1'b1, 400, n);
    in_win("R10", n, (H - 1) * DIV, H * DIV + 4);

    // R6 valid kicks keep the short timeout from expiring
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      cs_pulse(KMIN);
      for (int j = 0; j < 15; j++) begin
        @(negedge clk); if (rst_lo === 1'b0) seen = 1'b1;
      end
    end
    chk(!seen, "R6", int'(seen), 0);

    // R6 pulses one clock short do not restart: expiry follows
    cs_pulse(KMIN);
    n = 0;
    while (rst_lo === 1'b1 && n < 200) begin
      @(negedge clk); n++;
      cs = ((n % 12) >= 6 && (n % 12) < 6 + KMIN - 1) ? 1'b0 : 1'b1;
    end
    cs = 1'b1;
    in_win("R6", n, (TS - 1) * DIV - 4, TS * DIV + 6);

    // R5 pulse width
    wait_lvl(1'b1, 400, n);
    in_win("R5", n, (H - 1) * DIV, H * DIV + 2);

    // R8 / R7 stuck high: full timeout counted from pulse end
    wait_lvl(1'b0, 400, n);
    in_win("R8", n, (TS - 1) * DIV, TS * DIV + 4);
    chk(n <= TS * DIV + 4, "R7", n, TS * DIV);
    wait_lvl(1'b1, 400, n);

    // R7 stuck low: one restart then expiry
    @(negedge clk); cs = 1'b0;
    wait_lvl(1'b0, 400, n);
    in_win("R7", n, (TS - 1) * DIV, TS * DIV + KMIN + 8);
    cs = 1'b1;
    wait_lvl(1'b1, 400, n);

    // R4 medium code (change restarts count)
    @(negedge clk); sel = 2'b01;
    wait_lvl(1'b0, 600, n);
    in_win("R4", n, (TM - 1) * DIV, TM * DIV + 4);
    wait_lvl(1'b1, 400, n);

    // R4 long code
    @(negedge clk); sel = 2'b00;
    wait_lvl(1'b0, 600, n);
    in_win("R4", n, (TL - 1) * DIV, TL * DIV + 4);
    wait_lvl(1'b1, 400, n);

    // R4 disabled code never expires
    @(negedge clk); sel = 2'b11;
    seen = 1'b0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk); if (rst_lo === 1'b0) seen = 1'b1;
    end
    chk(!seen, "R4", int'(seen), 0);

    // R9 select change restarts the count
    @(negedge clk); sel = 2'b10;
    cs_pulse(KMIN);
    step(20);
    sel = 2'b01;
    wait_lvl(1'b0, 600, n);
    in_win("R9", n, (TM - 1) * DIV, TM * DIV + 4);
    wait_lvl(1'b1, 400, n);

    // R2 low supply asserts within three edges and holds
    sel = 2'b10;
    cs_pulse(KMIN);
    step(4);
    lv = 1'b1;
    wait_lvl(1'b0, 20, n);
    in_win("R2", n, 2, 3);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); if (rst_lo === 1'b1) seen = 1'b1;
      cs = ((i % 10) < 6) ? 1'b0 : 1'b1;
    end
    cs = 1'b1;
    chk(!seen, "R2", int'(seen), 0);

    // R3 hold after release, then R8 full timeout
    lv = 1'b0;
    wait_lvl(1'b1, 400, n);
    in_win("R3", n, (H - 1) * DIV + 2, H * DIV + 6);
    wait_lvl(1'b0, 400, n);
    in_win("R8", n, (TS - 1) * DIV, TS * DIV + 4);
    step(5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule